// File: doc/BRIEF.md
# Shift-Register FIFO Queue

This block is a first-in-first-out queue held in a register file whose entries move toward a fixed head slot. Slot 0 always holds the oldest word and drives the data output directly, so a read costs no address decode on the output path. A fill counter gives both the number of valid words and the index of the next free slot. A write stores a word at the tail, and a read shifts every valid word one place toward the head.

A read and a write may be strobed in the same cycle. The word count then stays the same, the queue shifts, and the new word lands just behind the last valid entry. Everything runs in one clock domain with an active-low asynchronous reset. Strobes that would underflow or overflow the queue have no effect.

Top module: `shift_fifo`

## Requirements
- R1: While reset is held low, and after it is released with no strobes, `level_o` is 0, `empty_o` is 1, `full_o` is 0 and `rd_data_o` is 0.
- R2: `rd_data_o` always shows the oldest word still in the queue. Words leave in the order they were written.
- R3: A write with no read, while not full, adds one word. `level_o` goes up by 1 on the next clock and `empty_o` goes to 0.
- R4: A read with no write, while not empty, removes the head word. `level_o` goes down by 1 on the next clock, the next-oldest word appears on `rd_data_o` and `full_o` goes to 0.
- R5: A read and a write in the same cycle, while not empty, keep `level_o` the same, remove the head word and add the new word at the tail.
- R6: `full_o` is 1 exactly when `level_o` equals DEPTH (8). `empty_o` is 1 exactly when `level_o` is 0.
- R7: A write with no read while full has no effect on the level or on the stored words.
- R8: A read while empty has no effect. When a write comes in the same cycle, it is handled as a plain write.
- R9: `level_o` never goes above DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wr_data_i | input | 8 | Word to write |
| rd_data_o | output | 8 | Head word (slot 0) |
| full_o | output | 1 | Queue holds DEPTH words |
| empty_o | output | 1 | Queue holds no words |
| level_o | output | 4 | Number of valid words |

## Verification
A wrong fill count shows up on `level_o` and the flags at the next clock edge. Its effect on data appears only when the affected slot reaches the head: a tail write that lands one slot too high or too low will surface on `rd_data_o` some reads later, as a word that is missing, repeated or stale. The scoreboard drains the queue completely after each pattern, so every stored word is eventually compared at the head. The full and empty cases are visited on purpose, so that ignored strobes can be shown to leave both the count and the word order unchanged.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_PUSH  = 2'b01,
    OP_POP   = 2'b10,
    OP_SWAP  = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/shift_fifo_ctrl.sv
module shift_fifo_ctrl
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  output fifo_op_e      op_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [CW-1:0] level_q, level_d;
  logic          is_full, is_empty;

  assign is_full  = (level_q == CW'(DEPTH));
  assign is_empty = (level_q == '0);

  always_comb begin
    op_o = OP_IDLE;
    if (rd_i && !is_empty)      op_o = wr_i ? OP_SWAP : OP_POP;
    else if (wr_i && !is_full)  op_o = OP_PUSH; // covers rd+wr while empty
  end

  always_comb begin
    level_d = level_q;
    unique case (op_o)
      OP_PUSH: level_d = level_q + 1'b1;
      OP_POP:  level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;
  assign full_o  = is_full;
  assign empty_o = is_empty;
endmodule

// File: rtl/shift_fifo_slot.sv
module shift_fifo_slot
  import shift_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX   = 0,
  parameter int CW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fifo_op_e         op_i,
  input  logic [CW-1:0]    level_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] upper_i,   // neighbour slot IDX+1
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q, d;

  always_comb begin
    d = q;
    unique case (op_i)
      OP_PUSH: if (level_i == CW'(IDX)) d = wr_data_i;
      OP_POP:  d = upper_i;
      OP_SWAP: d = (level_i == CW'(IDX + 1)) ? wr_data_i : upper_i;
      default: d = q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    level_o
);
  fifo_op_e         op;
  logic [CW-1:0]    level;
  logic [WIDTH-1:0] slot_q [DEPTH+1];

  shift_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .op_o    (op),
    .level_o (level),
    .full_o  (full_o),
    .empty_o (empty_o)
  );

  // Beyond the last slot the shift input reads zero.
  assign slot_q[DEPTH] = '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    shift_fifo_slot #(.WIDTH(WIDTH), .IDX(i), .CW(CW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .op_i      (op),
      .level_i   (level),
      .wr_data_i (wr_data_i),
      .upper_i   (slot_q[i+1]),
      .q_o       (slot_q[i])
    );
  end

  assign rd_data_o = slot_q[0];
  assign level_o   = level;
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             full_o,
  input logic             empty_o,
  input logic [CW-1:0]    level_o
);
  // R6
  full_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (level_o == CW'(DEPTH)));
  // R6
  empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (level_o == '0));
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
  // R3
  push_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && !full_o) |=> level_o == $past(level_o) + 1'b1);
  // R4
  pop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !empty_o) |=> level_o == $past(level_o) - 1'b1);
  // R5
  swap_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i && !empty_o) |=> $stable(level_o));
  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && full_o) |=> ($stable(level_o) && $stable(rd_data_o)));
  // R8
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && empty_o) |=> ($stable(level_o) && $stable(rd_data_o)));
  // R2
  first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && empty_o) |=> rd_data_o == $past(wr_data_i));
endmodule

bind shift_fifo shift_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/tb_shift_fifo.sv
`timescale 1ns/1ps
module tb_shift_fifo;
  localparam int W = 8, D = 8;
  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic full, empty;
  logic [3:0] lvl;
  int total = 0, bad = 0;
  logic [W-1:0] model[$];

  always #2.5 clk = ~clk;

  shift_fifo dut (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .wr_data_i(din), .rd_data_o(dout), .full_o(full), .empty_o(empty), .level_o(lvl));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: after each step compare outputs against the scoreboard queue
  task automatic monitor(input string req);
    check({req, " level"}, lvl, model.size());
    check("R6 full", full, model.size() == D);
    check("R6 empty", empty, model.size() == 0);
    if (model.size() > 0) check({req, " R2 head"}, dout, model[0]);
  endtask

  // driver: apply one cycle and update scoreboard
  task automatic step(input logic w, input logic r, input logic [W-1:0] d, input string req);
    int n;
    n = model.size();
    wr = w; rd = r; din = d;
    @(posedge clk); #1;
    wr = 0; rd = 0;
    if (r && n > 0) void'(model.pop_front());
    if (w && (n < D || (r && n > 0))) model.push_back(d);
    monitor(req);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 level rst", lvl, 0);
    check("R1 empty rst", empty, 1);
    check("R1 full rst", full, 0);
    check("R1 data rst", dout, 0);
    #10 rst_n = 1;
    @(negedge clk);
    monitor("R1");
    step(0, 1, 8'h00, "R8 pop empty");
    check("R8 data", dout, 0);
    for (int i = 0; i < D; i++) step(1, 0, 8'h10 + 8'(i), "R3");
    check("R6 full at 8", full, 1);
    step(1, 0, 8'hEE, "R7");
    step(1, 0, 8'hEF, "R7");
    check("R9 level", lvl, D);
    step(1, 1, 8'h55, "R5 swap full");
    step(0, 1, 8'h00, "R4 pop from full");
    check("R4 full clear", full, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 8'h60 + 8'(i), "R5");
    while (model.size() > 0) step(0, 1, 8'h00, "R4 drain");
    step(1, 1, 8'hA5, "R8 rw empty");
    check("R8 level", lvl, 1);
    check("R8 data", dout, 8'hA5);
    for (int i = 0; i < 40; i++) step(1'((i * 7) % 3 != 0), 1'((i * 5) % 4 == 0), 8'(i * 13), "R2 mix");
    while (model.size() > 0) step(0, 1, 8'h00, "R4 drain2");
    step(0, 1, 8'h00, "R8 pop empty2");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule